// File: doc/BRIEF.md
# Floating-Point Status Register Controller

This block keeps the floating-point status word of a processor core. An external arithmetic unit reports each finished operation with a valid pulse and five IEEE 754 exception flags. The block turns those flags into the current-exception field. It decides whether an enabled exception must trap the core. If there is no trap, it folds the flags into the sticky accrued-exception field. For compare operations it also records the outcome as a 2-bit condition code in one of four condition fields, chosen by an index.

Software reads the whole status word. It can write it in two ways: a full write, and a write that leaves the trap-type field as it is. The version, current-exception and trap-type fields are held apart from the main register and merged in only when the word is read. The stored rounding field is decoded into a rounding-mode output for the arithmetic unit.

Top module: `fpsr_ctrl`

## Requirements
- R1: After reset, `rd_data` equals the version constant placed at bits 19:17 with every other bit zero, `trap_req` is low and `rnd_mode` is 0.
- R2: An accepted event loads the current-exception field (bits 4:0) from `ev_flags`, where bit 4 = invalid, 3 = overflow, 2 = underflow, 1 = divide-by-zero and 0 = inexact. An event with no flag set clears both the current-exception field and the trap-type field (bits 16:14).
- R3: When the current-exception bits of an event intersect the trap-enable mask (bits 27:23, same bit order), `trap_req` is high for exactly the one cycle after that event, and the trap-type field reads 3'b001.
- R4: An event that does not trap ORs its current-exception bits into the accrued field (bits 9:5) and clears the trap type. A trapping event leaves the accrued field unchanged.
- R5: A compare outcome is encoded as equal 00, less 01, greater 10, unordered 11. When several outcome inputs are high, unordered takes priority over less, and less over greater.
- R6: `cmp_sel` 0, 1, 2 and 3 select the condition field at bits 11:10, 33:32, 35:34 and 37:36. Only the selected field changes.
- R7: A signaling compare (`cmp_signaling`=1) whose outcome is unordered raises the invalid exception even when `ev_flags` is zero. A quiet compare adds no flag.
- R8: A compare whose exceptions trap leaves every condition field unchanged.
- R9: `rnd_mode` decodes bits 31:30 as follows: 0 = nearest-even, 1 = toward zero, 2 = toward plus infinity, 3 = toward minus infinity.
- R10: A full write (`sw_wr`) stores every bit of `sw_wdata` except 19:17, 16:14 and 4:0 into the main register. It loads the current-exception and trap-type fields from bits 4:0 and 16:14 of `sw_wdata`. `rd_data` is the OR of the main register, those two fields and the version constant.
- R11: A trap-type-preserving write (`sw_wr_keep_tt`) acts like R10 but leaves the trap-type field as it was. If both write strobes are high, the full write applies.
- R12: A software write in the same cycle as an event discards the event: no trap, no accrual and no condition-code change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Operation or compare completed this cycle |
| ev_flags | input | 5 | IEEE exception flags of the completed event |
| ev_is_cmp | input | 1 | Event is a compare |
| cmp_lt | input | 1 | Compare outcome: less |
| cmp_gt | input | 1 | Compare outcome: greater |
| cmp_uo | input | 1 | Compare outcome: unordered |
| cmp_signaling | input | 1 | 1 = signaling compare, 0 = quiet |
| cmp_sel | input | 2 | Index of the condition field to write |
| sw_wr | input | 1 | Full software write |
| sw_wr_keep_tt | input | 1 | Software write that keeps the trap type |
| sw_wdata | input | 64 | Software write data |
| rd_data | output | 64 | Assembled status word |
| trap_req | output | 1 | One-cycle floating-point trap request |
| rnd_mode | output | 2 | Decoded rounding mode |

## Verification
A software write and a completing event can land on the same clock edge. The write must win, and the event must leave no trace. The bench provokes this directly by arming a trap and then firing a trapping event together with a write. It also mixes both kinds of strobe at random over a long run. The result is judged against a behavioural model every cycle: `trap_req` must stay low, and the read-back word must equal the written data with the accrued and condition fields untouched by the dropped event.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;
  parameter int unsigned REG_W    = 64;
  parameter int unsigned FLAG_W   = 5;
  parameter int unsigned CC_W     = 2;
  parameter int unsigned NUM_CC   = 4;
  parameter int unsigned TT_W     = 3;
  parameter int unsigned VER_W    = 3;
  localparam int unsigned CC_SEL_W = $clog2(NUM_CC);

  // field positions (low bit of each field)
  localparam int unsigned RND_LO    = 30;
  localparam int unsigned TEM_LO    = 23;
  localparam int unsigned VER_LO    = 17;
  localparam int unsigned TT_LO     = 14;
  localparam int unsigned CC0_LO    = 10;
  localparam int unsigned AEXC_LO   = 5;
  localparam int unsigned CEXC_LO   = 0;
  localparam int unsigned CC_EXT_LO = CC0_LO + 22;

  localparam int unsigned FL_INV = 4;

  localparam logic [TT_W-1:0] TT_IEEE = 3'b001;

  typedef enum logic [1:0] {
    RM_NEAREST = 2'd0,
    RM_ZERO    = 2'd1,
    RM_POS_INF = 2'd2,
    RM_NEG_INF = 2'd3
  } rnd_mode_e;

  typedef enum logic [CC_W-1:0] {
    CC_EQ = 2'd0,
    CC_LT = 2'd1,
    CC_GT = 2'd2,
    CC_UO = 2'd3
  } cc_code_e;

  function automatic int unsigned cc_lsb(input int unsigned idx);
    return (idx == 0) ? CC0_LO : CC_EXT_LO + CC_W * (idx - 1);
  endfunction

  function automatic cc_code_e cc_encode(input logic lt, input logic gt, input logic uo);
    if (uo)      return CC_UO;
    else if (lt) return CC_LT;
    else if (gt) return CC_GT;
    else         return CC_EQ;
  endfunction

  function automatic logic [FLAG_W-1:0] build_cexc(input logic [FLAG_W-1:0] flags,
                                                   input logic sig_unord);
    logic [FLAG_W-1:0] c;
    c = flags;
    if (sig_unord) c[FL_INV] = 1'b1;
    return c;
  endfunction

  function automatic logic [REG_W-1:0] split_mask();
    logic [REG_W-1:0] m;
    m = '0;
    m[VER_LO +: VER_W]   = '1;
    m[TT_LO +: TT_W]     = '1;
    m[CEXC_LO +: FLAG_W] = '1;
    return m;
  endfunction
endpackage

// File: rtl/fpsr_exc_eval.sv
module fpsr_exc_eval
  import fpsr_pkg::*;
(
  input  logic [FLAG_W-1:0] flags_i,
  input  logic              sig_unord_i,
  input  logic [FLAG_W-1:0] tem_i,
  output logic [FLAG_W-1:0] cexc_o,
  output logic              trap_hit_o
);
  always_comb begin
    cexc_o     = build_cexc(flags_i, sig_unord_i);
    trap_hit_o = |(cexc_o & tem_i);
  end
endmodule

// File: rtl/fpsr_cc_update.sv
module fpsr_cc_update
  import fpsr_pkg::*;
(
  input  logic [REG_W-1:0]    base_i,
  input  logic                en_i,
  input  logic [CC_SEL_W-1:0] sel_i,
  input  cc_code_e            code_i,
  output logic [REG_W-1:0]    merged_o
);
  logic [NUM_CC-1:0][REG_W-1:0] clr_m;
  logic [NUM_CC-1:0][REG_W-1:0] set_m;

  for (genvar k = 0; k < NUM_CC; k++) begin : g_fld
    localparam int unsigned LO = cc_lsb(k);
    logic hit;
    assign hit      = en_i && (sel_i == CC_SEL_W'(k));
    assign clr_m[k] = hit ? ({{(REG_W-CC_W){1'b0}}, {CC_W{1'b1}}} << LO) : '0;
    assign set_m[k] = hit ? ({{(REG_W-CC_W){1'b0}}, code_i} << LO) : '0;
  end

  always_comb begin
    logic [REG_W-1:0] acc_c;
    logic [REG_W-1:0] acc_s;
    acc_c = '0;
    acc_s = '0;
    for (int k = 0; k < NUM_CC; k++) begin
      acc_c = acc_c | clr_m[k];
      acc_s = acc_s | set_m[k];
    end
    merged_o = (base_i & ~acc_c) | acc_s;
  end
endmodule

// File: rtl/fpsr_rnd_dec.sv
module fpsr_rnd_dec
  import fpsr_pkg::*;
(
  input  logic [1:0] fld_i,
  output rnd_mode_e  mode_o
);
  always_comb begin
    unique case (fld_i)
      2'd0:    mode_o = RM_NEAREST;
      2'd1:    mode_o = RM_ZERO;
      2'd2:    mode_o = RM_POS_INF;
      default: mode_o = RM_NEG_INF;
    endcase
  end
endmodule

// File: rtl/fpsr_ctrl.sv
module fpsr_ctrl
  import fpsr_pkg::*;
#(
  parameter logic [VER_W-1:0] VERSION = 3'd5
)(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ev_valid,
  input  logic [FLAG_W-1:0]   ev_flags,
  input  logic                ev_is_cmp,
  input  logic                cmp_lt,
  input  logic                cmp_gt,
  input  logic                cmp_uo,
  input  logic                cmp_signaling,
  input  logic [CC_SEL_W-1:0] cmp_sel,
  input  logic                sw_wr,
  input  logic                sw_wr_keep_tt,
  input  logic [REG_W-1:0]    sw_wdata,
  output logic [REG_W-1:0]    rd_data,
  output logic                trap_req,
  output logic [1:0]          rnd_mode
);
  localparam logic [REG_W-1:0] SPLIT_M = split_mask();

  logic [REG_W-1:0]  main_q;
  logic [FLAG_W-1:0] cexc_q;
  logic [TT_W-1:0]   tt_q;
  logic              trap_q;

  // named internal events, also observed by the checker
  logic              sw_any;
  logic              ev_go;
  logic              ev_trap;
  logic              ev_accum;
  logic [FLAG_W-1:0] cexc_new;
  logic              trap_hit;
  logic [REG_W-1:0]  cc_merged;
  cc_code_e          cc_code;
  rnd_mode_e         rm_dec;

  assign sw_any   = sw_wr | sw_wr_keep_tt;
  assign ev_go    = ev_valid & ~sw_any;
  assign ev_trap  = ev_go & trap_hit;
  assign ev_accum = ev_go & ~trap_hit;
  assign cc_code  = cc_encode(cmp_lt, cmp_gt, cmp_uo);

  fpsr_exc_eval u_exc (
    .flags_i     (ev_flags),
    .sig_unord_i (ev_is_cmp & cmp_signaling & cmp_uo),
    .tem_i       (main_q[TEM_LO +: FLAG_W]),
    .cexc_o      (cexc_new),
    .trap_hit_o  (trap_hit)
  );

  fpsr_cc_update u_cc (
    .base_i   (main_q),
    .en_i     (ev_is_cmp),
    .sel_i    (cmp_sel),
    .code_i   (cc_code),
    .merged_o (cc_merged)
  );

  fpsr_rnd_dec u_rnd (
    .fld_i  (main_q[RND_LO +: 2]),
    .mode_o (rm_dec)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_q <= '0;
      cexc_q <= '0;
      tt_q   <= '0;
      trap_q <= 1'b0;
    end else begin
      trap_q <= ev_trap;
      if (sw_any) begin
        main_q <= sw_wdata & ~SPLIT_M;
        cexc_q <= sw_wdata[CEXC_LO +: FLAG_W];
        if (sw_wr) tt_q <= sw_wdata[TT_LO +: TT_W];
      end else if (ev_go) begin
        cexc_q <= cexc_new;
        tt_q   <= ev_trap ? TT_IEEE : '0;
        if (ev_accum)
          main_q <= cc_merged | ({{(REG_W-FLAG_W){1'b0}}, cexc_new} << AEXC_LO);
      end
    end
  end

  always_comb begin
    rd_data = main_q;
    rd_data[CEXC_LO +: FLAG_W] = rd_data[CEXC_LO +: FLAG_W] | cexc_q;
    rd_data[TT_LO +: TT_W]     = rd_data[TT_LO +: TT_W] | tt_q;
    rd_data[VER_LO +: VER_W]   = rd_data[VER_LO +: VER_W] | VERSION;
  end

  assign trap_req = trap_q;
  assign rnd_mode = rm_dec;
endmodule

// File: rtl/fpsr_ctrl_chk.sv
module fpsr_ctrl_chk
  import fpsr_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             sw_any,
  input logic             ev_go,
  input logic             ev_accum,
  input logic             ev_is_cmp,
  input logic [REG_W-1:0] rd_data,
  input logic             trap_req,
  input logic [1:0]       rnd_mode
);
  logic [2*NUM_CC-1:0] cc_all;
  assign cc_all = {rd_data[CC_EXT_LO +: 2*(NUM_CC-1)], rd_data[CC0_LO +: CC_W]};

  AST_TRAP_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> $past(ev_go)); // R3

  AST_TRAP_TYPE_IEEE: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> rd_data[TT_LO +: TT_W] == TT_IEEE); // R3

  AST_TRAP_HOLDS_ACCRUED: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> rd_data[AEXC_LO +: FLAG_W] == $past(rd_data[AEXC_LO +: FLAG_W])); // R4

  AST_ACCRUED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sw_any) |-> ((rd_data[AEXC_LO +: FLAG_W] & $past(rd_data[AEXC_LO +: FLAG_W]))
                        == $past(rd_data[AEXC_LO +: FLAG_W]))); // R4

  AST_NOFLAG_CLEARS_TT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ev_go) && rd_data[CEXC_LO +: FLAG_W] == '0) |-> rd_data[TT_LO +: TT_W] == '0); // R2

  AST_CC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(sw_any) && !$past(ev_accum && ev_is_cmp)) |-> $stable(cc_all)); // R6

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sw_any) |-> !trap_req); // R12

  AST_RND_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(rd_data[RND_LO +: 2]) |-> $stable(rnd_mode)); // R9
endmodule

bind fpsr_ctrl fpsr_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sw_any    (sw_any),
  .ev_go     (ev_go),
  .ev_accum  (ev_accum),
  .ev_is_cmp (ev_is_cmp),
  .rd_data   (rd_data),
  .trap_req  (trap_req),
  .rnd_mode  (rnd_mode)
);

// File: tb/fpsr_ctrl_tb_top.sv
`timescale 1ns/1ps
module fpsr_ctrl_tb_top;
  localparam logic [2:0] VER = 3'd5;
  localparam logic [63:0] SPLIT = (64'h7 << 17) | (64'h7 << 14) | 64'h1f;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_valid = 0, ev_is_cmp = 0, cmp_lt = 0, cmp_gt = 0, cmp_uo = 0, cmp_signaling = 0;
  logic [4:0] ev_flags = '0;
  logic [1:0] cmp_sel = '0;
  logic sw_wr = 0, sw_wr_keep_tt = 0;
  logic [63:0] sw_wdata = '0;
  logic [63:0] rd_data;
  logic trap_req;
  logic [1:0] rnd_mode;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;
  string cur_req = "R1";

  // behavioural reference state
  logic [63:0] m_main = '0;
  logic [4:0]  m_cx = '0;
  logic [2:0]  m_tt = '0;
  logic        m_trap = 0;

  always #10 clk = ~clk;

  fpsr_ctrl #(.VERSION(VER)) dut_i (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_flags(ev_flags),
    .ev_is_cmp(ev_is_cmp), .cmp_lt(cmp_lt), .cmp_gt(cmp_gt), .cmp_uo(cmp_uo),
    .cmp_signaling(cmp_signaling), .cmp_sel(cmp_sel), .sw_wr(sw_wr),
    .sw_wr_keep_tt(sw_wr_keep_tt), .sw_wdata(sw_wdata), .rd_data(rd_data),
    .trap_req(trap_req), .rnd_mode(rnd_mode)
  );

  function automatic logic [63:0] exp_word();
    return m_main | 64'(m_cx) | (64'(m_tt) << 14) | (64'(VER) << 17);
  endfunction

  always @(posedge clk) begin
    logic [4:0] fl;
    int pos;
    logic [1:0] code;
    if (!rst_n) begin
      m_main = '0; m_cx = '0; m_tt = '0; m_trap = 0;
    end else begin
      m_trap = 0;
      if (sw_wr || sw_wr_keep_tt) begin
        m_main = sw_wdata & ~SPLIT;
        m_cx = sw_wdata[4:0];
        if (sw_wr) m_tt = sw_wdata[16:14];
      end else if (ev_valid) begin
        fl = ev_flags;
        if (ev_is_cmp && cmp_signaling && cmp_uo) fl[4] = 1'b1;
        m_cx = fl;
        if ((fl & m_main[27:23]) != 5'd0) begin
          m_tt = 3'd1; m_trap = 1;
        end else begin
          m_tt = 3'd0;
          m_main[9:5] = m_main[9:5] | fl;
          if (ev_is_cmp) begin
            code = cmp_uo ? 2'd3 : cmp_lt ? 2'd1 : cmp_gt ? 2'd2 : 2'd0;
            pos = (cmp_sel == 2'd0) ? 10 : 30 + 2 * int'(cmp_sel);
            m_main[pos +: 2] = code;
          end
        end
      end
    end
  end

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      n_chk++;
      if (rd_data !== exp_word() || trap_req !== m_trap || rnd_mode !== m_main[31:30]) begin
        n_bad++;
        $display("FAIL %s model: rd=%h trap=%b rm=%0d expected rd=%h trap=%b rm=%0d",
                 cur_req, rd_data, trap_req, rnd_mode, exp_word(), m_trap, m_main[31:30]);
      end
    end
  end

  task automatic xchk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    ev_valid = 0; ev_flags = '0; ev_is_cmp = 0; cmp_lt = 0; cmp_gt = 0; cmp_uo = 0;
    cmp_signaling = 0; cmp_sel = '0; sw_wr = 0; sw_wr_keep_tt = 0; sw_wdata = '0;
  endtask

  task automatic wr(input logic full, input logic [63:0] d);
    sw_wr = full; sw_wr_keep_tt = ~full; sw_wdata = d;
    @(negedge clk); idle();
  endtask

  task automatic op(input logic [4:0] f);
    ev_valid = 1; ev_flags = f;
    @(negedge clk); idle();
  endtask

  task automatic cmp(input logic [1:0] sel, input logic lt, input logic gt, input logic uo,
                     input logic sig, input logic [4:0] f);
    ev_valid = 1; ev_is_cmp = 1; cmp_sel = sel; cmp_lt = lt; cmp_gt = gt; cmp_uo = uo;
    cmp_signaling = sig; ev_flags = f;
    @(negedge clk); idle();
  endtask

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cur_req = "R1";
    xchk("R1 reset word", rd_data, 64'(VER) << 17);
    xchk("R1 reset trap", 64'(trap_req), 64'd0);
    xchk("R1 reset rnd", 64'(rnd_mode), 64'd0);

    cur_req = "R9";
    for (int m = 0; m < 4; m++) begin
      wr(1, 64'(m) << 30);
      xchk("R9 rounding decode", 64'(rnd_mode), 64'(m));
    end

    cur_req = "R10";
    wr(1, '1);
    xchk("R10 full write readback", rd_data, ~(64'h7 << 17) | (64'(VER) << 17));
    cur_req = "R11";
    wr(0, 64'h0);
    xchk("R11 tt kept", 64'(rd_data[16:14]), 64'd7);
    xchk("R11 cexc loaded", 64'(rd_data[4:0]), 64'd0);
    sw_wr = 1; sw_wr_keep_tt = 1; sw_wdata = 64'h0;
    @(negedge clk); idle();
    xchk("R11 both strobes: full write wins", 64'(rd_data[16:14]), 64'd0);

    cur_req = "R2";
    for (int b = 0; b < 5; b++) begin
      op(5'(1 << b));
      xchk("R2 flag to cexc", 64'(rd_data[4:0]), 64'(1 << b));
    end
    cur_req = "R4";
    xchk("R4 accrued union", 64'(rd_data[9:5]), 64'h1f);
    op(5'd0);
    xchk("R2 no flag clears cexc", 64'(rd_data[4:0]), 64'd0);

    cur_req = "R3";
    wr(1, (64'h10 << 23) | (64'h2 << 14));
    op(5'h10);
    xchk("R3 trap pulse", 64'(trap_req), 64'd1);
    xchk("R3 trap type", 64'(rd_data[16:14]), 64'd1);
    xchk("R4 accrued untouched on trap", 64'(rd_data[9:5]), 64'd0);
    @(negedge clk);
    xchk("R3 trap one cycle", 64'(trap_req), 64'd0);
    op(5'h01);
    xchk("R4 no trap clears tt", 64'(rd_data[16:14]), 64'd0);
    xchk("R4 accrued or", 64'(rd_data[9:5]), 64'd1);

    cur_req = "R6";
    wr(1, 64'h0);
    cmp(2'd0, 1, 0, 0, 0, 0); xchk("R5 R6 less in field0", 64'(rd_data[11:10]), 64'd1);
    cmp(2'd1, 0, 1, 0, 0, 0); xchk("R5 R6 greater in field1", 64'(rd_data[33:32]), 64'd2);
    cmp(2'd2, 1, 1, 1, 0, 0); xchk("R5 unordered priority field2", 64'(rd_data[35:34]), 64'd3);
    cmp(2'd3, 1, 1, 0, 0, 0); xchk("R5 less over greater field3", 64'(rd_data[37:36]), 64'd1);
    cmp(2'd1, 0, 0, 0, 0, 0); xchk("R5 equal field1", 64'(rd_data[33:32]), 64'd0);
    xchk("R6 other fields kept", {rd_data[37:34], rd_data[11:10]}, 64'b01_11_01);

    cur_req = "R7";
    cmp(2'd0, 0, 0, 1, 0, 0); xchk("R7 quiet unordered no flag", 64'(rd_data[4:0]), 64'd0);
    cmp(2'd0, 0, 0, 1, 1, 0); xchk("R7 signaling unordered invalid", 64'(rd_data[4:0]), 64'h10);
    cur_req = "R8";
    wr(1, 64'h10 << 23);
    cmp(2'd2, 1, 0, 0, 0, 5'h10);
    xchk("R8 trapping compare keeps field", 64'(rd_data[35:34]), 64'd0);
    xchk("R8 trap raised", 64'(trap_req), 64'd1);

    cur_req = "R12";
    ev_valid = 1; ev_flags = 5'h10; sw_wr = 1; sw_wdata = (64'h10 << 23) | 64'h3;
    @(negedge clk); idle();
    xchk("R12 write wins no trap", 64'(trap_req), 64'd0);
    xchk("R12 write data kept", rd_data, (64'h10 << 23) | 64'h3 | (64'(VER) << 17));

    cur_req = "MIX";
    for (int i = 0; i < 3000; i++) begin
      ev_valid = ($urandom_range(0, 2) != 0);
      ev_flags = 5'($urandom) & 5'($urandom);
      ev_is_cmp = $urandom_range(0, 1) != 0;
      cmp_lt = $urandom_range(0, 1) != 0; cmp_gt = $urandom_range(0, 1) != 0;
      cmp_uo = $urandom_range(0, 3) == 0; cmp_signaling = $urandom_range(0, 1) != 0;
      cmp_sel = 2'($urandom);
      sw_wr = $urandom_range(0, 15) == 0; sw_wr_keep_tt = $urandom_range(0, 15) == 0;
      sw_wdata = {$urandom, $urandom} & ~(64'h1f << 23) | ({59'd0, 5'($urandom) & 5'($urandom)} << 23);
      @(negedge clk);
    end
    idle();
    @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule